// File: doc/BRIEF.md
# Temperature Conversion Request Sequencer

This block decides when an external temperature sensor and compensation engine should run. Conversions come from two sources. An internal timer counts a 1 Hz tick and launches a conversion once every 64 seconds. Software can also write a 1 to a convert control bit to ask for a conversion. The block gives the engine a one-cycle start pulse and waits for its done pulse. It presents two readable status bits: a convert bit that follows a software request, and a busy bit that is high while the engine is running.

Software requests are delayed on purpose. The convert bit rises on the cycle after the write is accepted. The busy bit and the engine start follow only after a parameterised settling delay of fast-clock cycles, about 2 ms in a real system. For this reason software should poll the convert bit to follow its own request. Software requests run on a separate path from the periodic timer and never move its schedule. If a periodic slot comes due while the engine is busy, or while a software request is still in its settling delay, the slot is held and runs as soon as the engine is free.

Top module: `temp_conv_seq`

## Requirements
- R1: A write strobe with data 1, arriving while both the convert bit and the busy bit are 0, sets the convert bit on the next clock edge.
- R2: After an accepted software request, the busy bit rises exactly BUSY_DLY clock edges after the convert bit rose. The start output is high for that same single cycle.
- R3: A done pulse while a conversion is running clears the busy bit on the next edge. If the conversion came from a software request, the convert bit clears on that same edge.
- R4: A write of 1 has no effect while the busy bit is 1, or while the convert bit is already 1. It does not change the convert bit and it does not queue a later conversion.
- R5: A write of 0 never changes the convert bit. In particular it cannot clear the convert bit while a conversion is pending or running.
- R6: The timer counts ticks with a 6-bit wrapping counter. On every 64th tick after reset, a periodic conversion starts at that tick's own clock edge: busy rises and start pulses, and the convert bit stays 0. No conversion starts on the 63rd tick.
- R7: A software conversion that runs inside a period does not shift the periodic schedule. The next periodic start still falls on the 64th tick of that period.
- R8: A periodic slot that comes due while a software request is settling or running is held. It starts one cycle after the done pulse that frees the engine.
- R9: With reset held low, the convert, busy and start outputs are 0 after the clock edge.
- R10: A done pulse while no conversion is running is ignored, so a done pulse during the settling delay neither clears the convert bit nor stops the later start. The start output is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| wr_conv | input | 1 | Write strobe for the convert bit |
| wr_data | input | 1 | Data value written to the convert bit |
| eng_done | input | 1 | One-cycle pulse from the engine when the conversion and update are finished |
| eng_start | output | 1 | One-cycle pulse that starts the engine |
| conv_bit | output | 1 | Readable convert bit; high from an accepted software request until done |
| busy_bit | output | 1 | Readable busy bit; high while the engine is running |

## Verification
Every result has a fixed latency from the input edge that causes it. The convert bit is due one edge after the write. Busy and start are due BUSY_DLY edges after that. Clearing is due one edge after done, and a periodic start is due on the edge of its 64th tick. A held periodic slot is due two edges after the done that released it. The driver computes each of these cycle numbers from the requirements before it applies the stimulus, and queues the expected output values keyed by cycle number. The monitor samples the outputs on the falling edge. It compares only when its cycle count equals the queued cycle, and an entry whose cycle has already passed counts as a miss.

// File: rtl/temp_conv_pkg.sv
// Package: shared types for the temperature conversion sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package temp_conv_pkg;

    // Sequencer states: idle, software-request settling delay, engine running.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } conv_state_e;

endpackage

// File: rtl/period_timer.sv
// Module: period_timer
// Counts 1 Hz ticks in a freely wrapping counter and flags the tick that
// wraps it, which marks one periodic conversion slot.
// Assumes: tick is a single-cycle pulse; the count is never reset by requests.
module period_timer #(
    parameter int PERIOD_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic due
);
    localparam logic [PERIOD_W-1:0] LAST = {PERIOD_W{1'b1}};

    logic [PERIOD_W-1:0] secs_q;

    // Advance the seconds count on each tick, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            secs_q <= '0;
        end else if (tick) begin
            secs_q <= secs_q + 1'b1;
        end
    end

    // A slot is due on the tick that moves the count from its top value.
    always_comb begin
        due = tick && (secs_q == LAST);
    end
endmodule

// File: rtl/busy_delay.sv
// Module: busy_delay
// Counts fast-clock cycles while enabled and fires on the last cycle of a
// window BUSY_DLY cycles long.
// Assumes: BUSY_DLY >= 1; enable stays high until fire, then drops.
module busy_delay #(
    parameter int BUSY_DLY = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic fire
);
    localparam int CW = (BUSY_DLY < 2) ? 1 : $clog2(BUSY_DLY + 1);
    localparam logic [CW-1:0] LAST = CW'(BUSY_DLY - 1);

    logic [CW-1:0] cnt_q;

    // Count while the window is open; clear whenever it is closed.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Fire on the final cycle of the window.
    always_comb begin
        fire = en && (cnt_q == LAST);
    end
endmodule

// File: rtl/conv_ctrl.sv
// Module: conv_ctrl
// Control state machine. It accepts software requests, holds periodic slots
// pending, issues the engine start pulse and keeps the convert and busy bits.
// Assumes: done is a single-cycle pulse and is only meaningful while running.
module conv_ctrl
    import temp_conv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        due,
    input  logic        user_req,
    input  logic        done,
    input  logic        wait_fire,
    output conv_state_e state,
    output logic        conv_bit,
    output logic        busy_bit,
    output logic        start
);
    conv_state_e state_q;
    logic        conv_q;
    logic        busy_q;
    logic        start_q;
    logic        pend_q;
    logic        user_ok;

    // A request is taken only while both visible bits are low.
    always_comb begin
        user_ok = user_req && !busy_q && !conv_q;
    end

    // Sequence requests, hold periodic slots, and time the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            conv_q  <= 1'b0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (user_ok) begin
                        state_q <= ST_WAIT;
                        conv_q  <= 1'b1;
                        pend_q  <= pend_q | due;
                    end else if (pend_q || due) begin
                        state_q <= ST_RUN;
                        busy_q  <= 1'b1;
                        start_q <= 1'b1;
                        pend_q  <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    pend_q <= pend_q | due;
                    if (wait_fire) begin
                        state_q <= ST_RUN;
                        busy_q  <= 1'b1;
                        start_q <= 1'b1;
                    end
                end
                ST_RUN: begin
                    pend_q <= pend_q | due;
                    if (done) begin
                        state_q <= ST_IDLE;
                        busy_q  <= 1'b0;
                        conv_q  <= 1'b0;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Drive the registered state out to the ports.
    always_comb begin
        state    = state_q;
        conv_bit = conv_q;
        busy_bit = busy_q;
        start    = start_q;
    end
endmodule

// File: rtl/temp_conv_seq.sv
// Module: temp_conv_seq (top)
// Connects the period timer, the settling delay counter and the control
// state machine into the conversion request sequencer.
// Assumes: all inputs are synchronous to clk; tick_1hz and eng_done are pulses.
module temp_conv_seq
    import temp_conv_pkg::*;
#(
    parameter int PERIOD_W = 6,
    parameter int BUSY_DLY = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1hz,
    input  logic wr_conv,
    input  logic wr_data,
    input  logic eng_done,
    output logic eng_start,
    output logic conv_bit,
    output logic busy_bit
);
    conv_state_e state;
    logic        due;
    logic        wait_fire;
    logic        wait_en;
    logic        user_req;

    // Decode a software write of 1 and open the delay window while settling.
    always_comb begin
        user_req = wr_conv && wr_data;
        wait_en  = (state == ST_WAIT);
    end

    period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_1hz),
        .due   (due)
    );

    busy_delay #(.BUSY_DLY(BUSY_DLY)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (wait_en),
        .fire  (wait_fire)
    );

    conv_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .due       (due),
        .user_req  (user_req),
        .done      (eng_done),
        .wait_fire (wait_fire),
        .state     (state),
        .conv_bit  (conv_bit),
        .busy_bit  (busy_bit),
        .start     (eng_start)
    );
endmodule

// File: rtl/temp_conv_seq_chk.sv
// Module: temp_conv_seq_chk
// Protocol checker for the sequencer ports, attached to the top by bind.
// Assumes: synchronous active-low reset on rst_n.
module temp_conv_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_conv,
    input logic wr_data,
    input logic eng_done,
    input logic eng_start,
    input logic conv_bit,
    input logic busy_bit
);
    // R1: the convert bit only rises after a write of 1.
    p_conv_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_bit) |-> $past(wr_conv && wr_data));

    // R2: busy rises together with the start pulse.
    p_start_at_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_bit) |-> eng_start);

    // R3: busy falls only after done.
    p_busy_fall_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_bit) |-> $past(eng_done));

    // R3: the convert bit clears on the same edge as busy.
    p_conv_with_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_bit) |-> $fell(busy_bit));

    // R4: while running without done, both bits hold.
    p_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_bit && !eng_done) |=> ($stable(conv_bit) && busy_bit));

    // R5: a write of 0 never sets the convert bit.
    p_write_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_conv && !wr_data && !conv_bit) |=> !conv_bit);

    // R10: the start pulse lasts one cycle.
    p_start_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R10: a start never comes from a running state.
    p_start_from_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !$past(busy_bit));
endmodule

bind temp_conv_seq temp_conv_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_conv   (wr_conv),
    .wr_data   (wr_data),
    .eng_done  (eng_done),
    .eng_start (eng_start),
    .conv_bit  (conv_bit),
    .busy_bit  (busy_bit)
);

// File: tb/tb_temp_conv_seq.sv
// Scoreboard bench: the driver queues expected outputs by cycle number and
// the monitor compares them on the falling edge.
module tb_temp_conv_seq;
    localparam int D = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic wr = 1'b0;
    logic wd = 1'b0;
    logic done = 1'b0;
    logic start;
    logic conv;
    logic busy;

    // 50 MHz clock.
    always #10 clk = ~clk;

    temp_conv_seq #(.PERIOD_W(6), .BUSY_DLY(D)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick),
        .wr_conv   (wr),
        .wr_data   (wd),
        .eng_done  (done),
        .eng_start (start),
        .conv_bit  (conv),
        .busy_bit  (busy)
    );

    typedef struct {
        int    c;
        bit    cv;
        bit    bz;
        bit    st;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    // Count rising edges; outputs seen at the next falling edge belong to this count.
    always @(posedge clk) cyc <= cyc + 1;

    // Insert an expectation, keeping the queue ordered by cycle.
    task automatic push(input int c, input bit cv, input bit bz, input bit st, input string tag);
        exp_t e;
        int i;
        e.c = c; e.cv = cv; e.bz = bz; e.st = st; e.tag = tag;
        i = 0;
        while (i < q.size() && q[i].c <= c) i++;
        q.insert(i, e);
    endtask

    // Monitor: compare each expectation in the cycle it is due.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].c <= cyc) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (e.c < cyc) begin
                bad++;
                $display("FAIL %s: missed cycle %0d (actual cycle %0d, expected %0d)", e.tag, e.c, cyc, e.c);
            end else if (conv !== e.cv || busy !== e.bz || start !== e.st) begin
                bad++;
                $display("FAIL %s at cycle %0d: actual conv=%0b busy=%0b start=%0b expected conv=%0b busy=%0b start=%0b",
                         e.tag, cyc, conv, busy, start, e.cv, e.bz, e.st);
            end
        end
    end

    // Drive one cycle of inputs; they are sampled at the next rising edge.
    task automatic step(input bit t, input bit w, input bit d, input bit dn);
        tick = t; wr = w; wd = d; done = dn;
        @(negedge clk);
        tick = 0; wr = 0; wd = 0; done = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) step(0, 0, 0, 0);
    endtask

    // A complete software conversion with its timing expectations.
    task automatic user_conv(input string tag);
        int c;
        c = cyc;
        push(c + 1, 1, 0, 0, {tag, " R1 conv set"});
        push(c + D, 1, 0, 0, {tag, " R2 busy still low"});
        push(c + D + 1, 1, 1, 1, {tag, " R2 busy and start"});
        push(c + D + 2, 1, 1, 0, {tag, " R2 start single"});
        step(0, 1, 1, 0);
        idle(D + 1);
        push(cyc + 1, 0, 0, 0, {tag, " R3 cleared"});
        step(0, 0, 0, 1);
    endtask

    initial begin
        int c;
        @(negedge clk);
        // R9: reset state.
        push(cyc + 1, 0, 0, 0, "R9 in reset");
        idle(3);
        rst_n = 1'b1;
        push(cyc + 1, 0, 0, 0, "R9 after reset");
        idle(1);

        // R5: write of 0 while idle.
        push(cyc + 1, 0, 0, 0, "R5 idle write 0");
        step(0, 1, 0, 0);
        // R10: stray done while idle.
        push(cyc + 1, 0, 0, 0, "R10 stray done idle");
        step(0, 0, 0, 1);

        // Software conversion with disturbances in the settling window.
        c = cyc;
        push(c + 1, 1, 0, 0, "R1 conv set");
        push(c + D, 1, 0, 0, "R2 busy still low");
        push(c + D + 1, 1, 1, 1, "R2 busy and start on time (R4 repeat ignored)");
        push(c + D + 2, 1, 1, 0, "R2 start single");
        step(0, 1, 1, 0);
        push(cyc + 1, 1, 0, 0, "R4 repeat write while conv");
        step(0, 1, 1, 0);
        push(cyc + 1, 1, 0, 0, "R10 done in settling ignored");
        step(0, 0, 0, 1);
        idle(c + D + 2 - cyc);
        push(cyc + 1, 1, 1, 0, "R5 write 0 while running");
        step(0, 1, 0, 0);
        push(cyc + 1, 1, 1, 0, "R4 write 1 while busy");
        step(0, 1, 1, 0);
        push(cyc + 1, 0, 0, 0, "R3 both clear on done");
        step(0, 0, 0, 1);
        push(cyc + 1, 0, 0, 0, "R3 stays clear");
        idle(1);

        // R6: periodic start on the 64th tick.
        repeat (62) step(1, 0, 0, 0);
        push(cyc + 1, 0, 0, 0, "R6 no start on tick 63");
        step(1, 0, 0, 0);
        push(cyc + 1, 0, 1, 1, "R6 start on tick 64");
        step(1, 0, 0, 0);
        push(cyc + 1, 0, 1, 0, "R6 running");
        idle(1);
        push(cyc + 1, 0, 1, 0, "R4 write 1 during periodic run");
        step(0, 1, 1, 0);
        idle(3);
        push(cyc + 1, 0, 0, 0, "R3 periodic done");
        step(0, 0, 0, 1);
        push(cyc + D + 2, 0, 0, 0, "R4 no queued request");
        idle(D + 3);

        // R7: software conversion inside a period leaves the schedule alone.
        repeat (30) step(1, 0, 0, 0);
        user_conv("R7");
        repeat (32) step(1, 0, 0, 0);
        push(cyc + 1, 0, 0, 0, "R7 no start on tick 63");
        step(1, 0, 0, 0);
        push(cyc + 1, 0, 1, 1, "R7 start on tick 64");
        step(1, 0, 0, 0);
        idle(2);
        push(cyc + 1, 0, 0, 0, "R7 done");
        step(0, 0, 0, 1);
        idle(2);

        // R8: periodic slot held during a software request.
        repeat (63) step(1, 0, 0, 0);
        c = cyc;
        push(c + 1, 1, 0, 0, "R8 request accepted");
        step(0, 1, 1, 0);
        push(c + 2, 1, 0, 0, "R8 slot held in settling");
        step(1, 0, 0, 0);
        push(c + D + 1, 1, 1, 1, "R8 software start on time");
        idle(c + D + 2 - cyc);
        push(cyc + 1, 0, 0, 0, "R8 software done");
        push(cyc + 2, 0, 1, 1, "R8 held slot starts");
        push(cyc + 3, 0, 1, 0, "R8 held slot running");
        step(0, 0, 0, 1);
        idle(3);
        push(cyc + 1, 0, 0, 0, "R8 held slot done");
        step(0, 0, 0, 1);
        idle(3);

        finished = 1'b1;
        if (q.size() > 0) begin
            bad += q.size();
            total += q.size();
            $display("FAIL R0 leftover: actual %0d unchecked, expected 0", q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual run still going, expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule